// File: doc/BRIEF.md
# Keyboard Scan-Code Joypad Emulator

This block turns a stream of keyboard scan-code bytes into the button state of two emulated game-console joypads. A serial receiver upstream hands over one byte at a time with a valid strobe. The block tracks two kinds of prefix byte. One prefix marks the next code as a release. The other marks the next code as coming from the extended key set. Each mapped key drives one button bit.

The button state is presented on two read-only 8-bit console I/O ports, and each port is reachable at two addresses. The bits are active-low, so 0 means pressed. A pause key does not set any port bit. Instead it produces a single-cycle pause pulse, which goes to the non-maskable interrupt input of the console CPU; that CPU vectors to 0x0066. A reset key produces a reset request level. The same state also shows up as a bit on the second port.

Top module: `kbd_joypad_top`

## Requirements
- R1: After rst_ni deasserts, pad_a_o and pad_b_o read 0xFF, pause_o is 0 and reset_req_o is 0.
- R2: The make codes 1D, 1B, 1C, 23, 41 and 49 (no prefix) press pad 1 up, down, left, right, fire A and fire B. These clear pad_a_o bits 0, 1, 2, 3, 4 and 5 respectively.
- R3: A code preceded by F0 releases the mapped button and sets its bit back to 1. Releasing a button that is already released leaves it at 1.
- R4: The extended codes E0 75 and E0 72 press pad 2 up and down, which clears pad_a_o bits 6 and 7. The extended codes E0 6B and E0 74 press pad 2 left and right, which clears pad_b_o bits 0 and 1. For a release, F0 follows E0.
- R5: The codes 70 and 71 (no prefix) press pad 2 fire A and fire B, which clears pad_b_o bits 2 and 3. pad_b_o bits 7:5 always read 1.
- R6: Code 76 (no prefix) held down drives reset_req_o to 1 and clears pad_b_o bit 4. Its release restores both.
- R7: Code 05 (no prefix) does not change either port. On a press from the released state it raises pause_o for exactly one cycle. Repeated make codes while the key is held raise no further pulse. Releasing the key with F0 05 re-arms the pulse.
- R8: Any other code is ignored, and so is any mapped code with the wrong prefix state. For example, 75 without E0 has no effect, and neither has E0 1D.
- R9: Both prefix flags clear once a non-prefix code has been processed, so a prefix affects exactly one following code.
- R10: rd_data_o equals pad_a_o when port_addr_i is DC or C0. It equals pad_b_o when port_addr_i is DD or C1. It is FF for every other address.
- R11: Bytes on code_i with code_valid_i low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_valid_i | input | 1 | Byte strobe for code_i |
| code_i | input | 8 | Scan-code byte |
| port_addr_i | input | 8 | Console I/O port address for reads |
| rd_data_o | output | 8 | Read data for port_addr_i |
| pad_a_o | output | 8 | First console port byte, active-low buttons |
| pad_b_o | output | 8 | Second console port byte, active-low buttons |
| pause_o | output | 1 | One-cycle pause interrupt request |
| reset_req_o | output | 1 | Reset request level, high while the key is held |

## Verification
A code byte is accepted on the rising edge where code_valid_i is high. Its button change is visible on the port outputs for the whole cycle that follows that edge, and a pause pulse lasts for that same single cycle. The bench drives each byte on a falling edge and lowers the strobe one falling edge later. It then samples ports, pulse and reset level at that falling edge. Pause is sampled once more on the following falling edge to confirm the pulse is gone. rd_data_o is combinational from the port state and the address, so it is checked a short delay after the address changes.

// File: rtl/kbd_joypad_pkg.sv
package kbd_joypad_pkg;
  localparam int CODE_W  = 8;
  localparam int NUM_BTN = 13;           // port bits carried in state
  localparam int IDX_W   = 4;

  // button index: 0..7 -> port A bits, 8..12 -> port B bits 0..4
  localparam logic [IDX_W-1:0] IDX_A_UP  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_A_DN  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_A_LF  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_A_RT  = 4'd3;
  localparam logic [IDX_W-1:0] IDX_A_FA  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_A_FB  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_B_UP  = 4'd6;
  localparam logic [IDX_W-1:0] IDX_B_DN  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_B_LF  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_B_RT  = 4'd9;
  localparam logic [IDX_W-1:0] IDX_B_FA  = 4'd10;
  localparam logic [IDX_W-1:0] IDX_B_FB  = 4'd11;
  localparam logic [IDX_W-1:0] IDX_RST   = 4'd12;
  localparam logic [IDX_W-1:0] IDX_PAUSE = 4'd13;
  localparam logic [IDX_W-1:0] IDX_NONE  = 4'd15;

  typedef struct packed {
    logic              valid;
    logic              rel;
    logic              ext;
    logic [CODE_W-1:0] code;
  } key_evt_t;
endpackage

// File: rtl/scan_parser.sv
module scan_parser
  import kbd_joypad_pkg::*;
#(
  parameter logic [CODE_W-1:0] PFX_EXT = 8'hE0,
  parameter logic [CODE_W-1:0] PFX_REL = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output key_evt_t          evt_o
);
  logic ext_q, rel_q;
  logic is_ext, is_rel;

  assign is_ext = valid_i && (code_i == PFX_EXT);
  assign is_rel = valid_i && (code_i == PFX_REL);

  always_comb begin
    evt_o.valid = valid_i && !(code_i == PFX_EXT) && !(code_i == PFX_REL);
    evt_o.rel   = rel_q;
    evt_o.ext   = ext_q;
    evt_o.code  = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q <= 1'b0;
      rel_q <= 1'b0;
    end else if (evt_o.valid) begin
      ext_q <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      if (is_ext) ext_q <= 1'b1;
      if (is_rel) rel_q <= 1'b1;
    end
  end

  // R9
  flags_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.valid |=> (!ext_q && !rel_q));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(ext_q) && $stable(rel_q)));
endmodule

// File: rtl/key_map.sv
module key_map
  import kbd_joypad_pkg::*;
(
  input  key_evt_t         evt_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = IDX_NONE;
    if (evt_i.ext) begin
      unique case (evt_i.code)
        8'h75:   idx_o = IDX_B_UP;
        8'h72:   idx_o = IDX_B_DN;
        8'h6B:   idx_o = IDX_B_LF;
        8'h74:   idx_o = IDX_B_RT;
        default: idx_o = IDX_NONE;
      endcase
    end else begin
      unique case (evt_i.code)
        8'h1D:   idx_o = IDX_A_UP;
        8'h1B:   idx_o = IDX_A_DN;
        8'h1C:   idx_o = IDX_A_LF;
        8'h23:   idx_o = IDX_A_RT;
        8'h41:   idx_o = IDX_A_FA;
        8'h49:   idx_o = IDX_A_FB;
        8'h70:   idx_o = IDX_B_FA;
        8'h71:   idx_o = IDX_B_FB;
        8'h76:   idx_o = IDX_RST;
        8'h05:   idx_o = IDX_PAUSE;
        default: idx_o = IDX_NONE;
      endcase
    end
  end
endmodule

// File: rtl/btn_bank.sv
module btn_bank
  import kbd_joypad_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               rel_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [NUM_BTN-1:0] btn_no,
  output logic               pause_o
);
  logic pause_held_q, pause_q;
  logic hit_pause;

  assign hit_pause = valid_i && (idx_i == IDX_PAUSE);

  for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
    logic hit;
    assign hit = valid_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  btn_no[g] <= 1'b1;
      else if (hit) btn_no[g] <= rel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_held_q <= 1'b0;
      pause_q      <= 1'b0;
    end else begin
      pause_q <= hit_pause && !rel_i && !pause_held_q;
      if (hit_pause) pause_held_q <= !rel_i;
    end
  end

  assign pause_o = pause_q;

  // R7
  pause_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |=> !pause_o);

  // R7
  pause_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_o) |-> ($past(hit_pause) && !$past(rel_i)));

  // R3
  release_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rel_i && (int'(idx_i) < NUM_BTN)) |=> btn_no[$past(idx_i)]);

  // R11
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(btn_no) && !pause_o));
endmodule

// File: rtl/kbd_joypad_top.sv
module kbd_joypad_top
  import kbd_joypad_pkg::*;
#(
  parameter logic [7:0] ADDR_A  = 8'hDC,
  parameter logic [7:0] ADDR_AM = 8'hC0,
  parameter logic [7:0] ADDR_B  = 8'hDD,
  parameter logic [7:0] ADDR_BM = 8'hC1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [7:0]        port_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [7:0]        pad_a_o,
  output logic [7:0]        pad_b_o,
  output logic              pause_o,
  output logic              reset_req_o
);
  key_evt_t           evt;
  logic [IDX_W-1:0]   idx;
  logic [NUM_BTN-1:0] btn_n;

  scan_parser u_parser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (code_valid_i),
    .code_i  (code_i),
    .evt_o   (evt)
  );

  key_map u_map (
    .evt_i (evt),
    .idx_o (idx)
  );

  btn_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (evt.valid),
    .rel_i   (evt.rel),
    .idx_i   (idx),
    .btn_no  (btn_n),
    .pause_o (pause_o)
  );

  assign pad_a_o     = btn_n[7:0];
  assign pad_b_o     = {3'b111, btn_n[NUM_BTN-1:8]};
  assign reset_req_o = !btn_n[IDX_RST];

  always_comb begin
    if (port_addr_i == ADDR_A || port_addr_i == ADDR_AM)      rd_data_o = pad_a_o;
    else if (port_addr_i == ADDR_B || port_addr_i == ADDR_BM) rd_data_o = pad_b_o;
    else                                                      rd_data_o = 8'hFF;
  end

  // R7
  pause_no_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> ($stable(pad_a_o) && $stable(pad_b_o)));
endmodule

// File: tb/kbd_joypad_top_test.sv
module kbd_joypad_top_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       code_valid_i = 1'b0;
  logic [7:0] code_i = 8'h00;
  logic [7:0] port_addr_i = 8'h00;
  logic [7:0] rd_data_o, pad_a_o, pad_b_o;
  logic       pause_o, reset_req_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  logic [12:0] st = '1;     // expected active-low state
  bit held = 0;             // pause key held

  always #5ns clk_i = ~clk_i;

  kbd_joypad_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_valid_i(code_valid_i), .code_i(code_i),
    .port_addr_i(port_addr_i), .rd_data_o(rd_data_o), .pad_a_o(pad_a_o),
    .pad_b_o(pad_b_o), .pause_o(pause_o), .reset_req_o(reset_req_o)
  );

  // expected key table: -1 none, 0..12 port state index, 13 pause
  function automatic int bmap(bit ext, logic [7:0] c);
    if (ext) begin
      if (c == 8'h75) return 6;
      if (c == 8'h72) return 7;
      if (c == 8'h6B) return 8;
      if (c == 8'h74) return 9;
      return -1;
    end
    case (c)
      8'h1D: return 0;  8'h1B: return 1;  8'h1C: return 2;  8'h23: return 3;
      8'h41: return 4;  8'h49: return 5;  8'h70: return 10; 8'h71: return 11;
      8'h76: return 12; 8'h05: return 13;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] ea(); return st[7:0]; endfunction
  function automatic logic [7:0] eb(); return {3'b111, st[12:8]}; endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    code_i = b; code_valid_i = 1'b1;
    @(negedge clk_i);
    code_valid_i = 1'b0;
  endtask

  task automatic check_ports(string tag);
    chk({tag, " pad_a"}, pad_a_o, ea());
    chk({tag, " pad_b"}, pad_b_o, eb());
    chk({tag, " reset_req R6"}, {7'd0, reset_req_o}, {7'd0, ~st[12]});
  endtask

  // key event with model update; checks pulse in the cycle after acceptance
  task automatic key(bit ext, bit rel, logic [7:0] c, string tag);
    int m;
    bit exp_p;
    m = bmap(ext, c);
    if (ext) send(8'hE0);
    if (rel) send(8'hF0);
    send(c);
    exp_p = (m == 13) && !rel && !held;
    if (m == 13) held = !rel;
    if (m >= 0 && m < 13) st[m] = rel;
    check_ports(tag);
    chk({tag, " pause R7"}, {7'd0, pause_o}, {7'd0, exp_p});
    @(negedge clk_i);
    chk({tag, " pause gone R7"}, {7'd0, pause_o}, 8'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 pad_a", pad_a_o, 8'hFF);
    chk("R1 pad_b", pad_b_o, 8'hFF);
    chk("R1 pause", {7'd0, pause_o}, 8'd0);
    chk("R1 reset_req", {7'd0, reset_req_o}, 8'd0);

    // R2 R4 R5 R6 R8: sweep every code, both prefix states, press then release
    for (int e = 0; e < 2; e++) begin
      for (int c = 0; c < 256; c++) begin
        if (c == 8'hE0 || c == 8'hF0) continue;
        key(bit'(e), 1'b0, 8'(c), $sformatf("R2/R4/R5/R8 make e=%0d c=%h", e, c));
        key(bit'(e), 1'b1, 8'(c), $sformatf("R3 break e=%0d c=%h", e, c));
      end
    end

    // R3 release of already released button
    key(1'b0, 1'b1, 8'h1D, "R3 double release");

    // combined presses on both pads
    key(1'b0, 1'b0, 8'h1D, "R2 combo up");
    key(1'b1, 1'b0, 8'h74, "R4 combo right2");
    key(1'b0, 1'b0, 8'h71, "R5 combo fb2");
    key(1'b0, 1'b0, 8'h76, "R6 combo reset");
    chk("R2/R4/R5/R6 combo a", pad_a_o, 8'hFE);
    chk("R2/R4/R5/R6 combo b", pad_b_o, 8'hE5);

    // R7 repeat while held: no second pulse, release re-arms
    key(1'b0, 1'b0, 8'h05, "R7 press");
    key(1'b0, 1'b0, 8'h05, "R7 repeat");
    key(1'b0, 1'b0, 8'h05, "R7 repeat2");
    key(1'b0, 1'b1, 8'h05, "R7 release");
    key(1'b0, 1'b0, 8'h05, "R7 re-press");
    key(1'b0, 1'b1, 8'h05, "R7 release2");

    // R9 prefix consumed by one code
    key(1'b0, 1'b1, 8'h1D, "R9 release up");
    key(1'b0, 1'b0, 8'h1D, "R9 press after release");
    send(8'hE0); send(8'h1B);   // E0 1B ignored
    check_ports("R9 ext unmapped");
    key(1'b0, 1'b0, 8'h1B, "R9 plain after ext");
    chk("R9 down pressed", pad_a_o, 8'hFC);

    // R11 bytes without strobe
    code_i = 8'h1C; @(negedge clk_i);
    code_i = 8'hF0; @(negedge clk_i);
    code_i = 8'h1D; @(negedge clk_i);
    code_i = 8'h05; @(negedge clk_i);
    check_ports("R11 no strobe");
    chk("R11 no pause", {7'd0, pause_o}, 8'd0);
    key(1'b0, 1'b1, 8'h1D, "R11 flag not set");

    // R10 read mux over every address
    for (int a = 0; a < 256; a++) begin
      logic [7:0] exp;
      port_addr_i = 8'(a);
      #1ns;
      if (a == 8'hDC || a == 8'hC0)      exp = ea();
      else if (a == 8'hDD || a == 8'hC1) exp = eb();
      else                               exp = 8'hFF;
      chk($sformatf("R10 addr %h", a), rd_data_o, exp);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule